// File: doc/BRIEF.md
# Line-Coalescing Request Buffer

This block sits between a group of load/store function units and one lane of the level-1 data cache. Every function unit owns exactly one row of the buffer and writes it through a private port. No port is shared, so no wide multiplexer is needed in front of the storage. A row holds a cache-line address (the address with its low four bits removed), a 16-bit byte-enable mask, the store data for that line, and a load/store flag.

Whenever any row is occupied, the buffer picks the lowest-numbered occupied row as the leader of a batch. It then takes every occupied row whose line address equals the leader's and ORs their byte masks. The whole batch goes to the cache as one 128-bit access: a single read or a single write on a valid/ready port. Store data is assembled byte by byte from the batch members. If two members of a store batch enable the same byte, a conflict flag is raised with the request. When the access completes, every batch member gets a one-cycle completion pulse and its row becomes free in the same cycle. For loads, the returned line is presented with that pulse.

Two instances are used, one per lane, split on address bit 4. The upstream logic guarantees that rows occupied at the same time are either all loads or all stores.

Top module: `l0_merge_buf`

## Requirements
- R1: After a synchronous active-low reset, `row_busy`, `done` and `l1_req_valid` are all zero.
- R2: A write on `wr_en[i]` to a free row makes `row_busy[i]` high from the next cycle. A write to a row that is busy is ignored and leaves the stored request unchanged.
- R3: A batch is led by the lowest-indexed busy row. `l1_req_line` and `l1_req_write` carry that row's line address and store flag (1 = write).
- R4: A batch contains every row that is busy when the batch forms and whose line address equals the leader's. `l1_req_mask` is the OR of their masks, with bit k enabling byte k, i.e. data bits 8k+7..8k.
- R5: A row that becomes busy after its batch has formed is not part of that batch, even when its line matches. It is served in a later batch.
- R6: For a store batch, byte k of `l1_req_wdata` comes from the lowest-indexed member whose mask enables byte k. Bytes that no member enables are zero.
- R7: `l1_req_conflict` is high with a store request exactly when two members of its batch enable a common byte. It is low for load batches.
- R8: While `l1_req_valid` is high and `l1_req_ready` is low, the request stays valid and its line, mask and write flag do not change.
- R9: A store batch completes on its handshake cycle. In the next cycle `done` pulses for exactly one cycle on the batch rows, and those rows are free.
- R10: A load batch waits for `l1_rsp_valid`. In the next cycle `done` pulses on exactly the batch rows, `rd_line` equals the response data, and those rows are free. No completion pulse occurs while a request is being offered.
- R11: `done` never pulses for a row that was not busy in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | N_ROWS | Per-row write strobe, one per function unit |
| wr_store | input | N_ROWS | Per-row store flag (1 = store) |
| wr_line | input | N_ROWS*LINE_AW | Per-row line address |
| wr_mask | input | N_ROWS*LINE_BYTES | Per-row byte-enable mask |
| wr_data | input | N_ROWS*LINE_BYTES*8 | Per-row store data, aligned to the line |
| row_busy | output | N_ROWS | Row holds an unfinished request |
| done | output | N_ROWS | One-cycle completion pulse per row |
| rd_line | output | LINE_BYTES*8 | Line returned by the last load batch |
| l1_req_valid | output | 1 | Cache request offered |
| l1_req_ready | input | 1 | Cache accepts the request |
| l1_req_write | output | 1 | 1 = write, 0 = read |
| l1_req_line | output | LINE_AW | Line address of the batch |
| l1_req_mask | output | LINE_BYTES | Merged byte mask |
| l1_req_wdata | output | LINE_BYTES*8 | Merged store data |
| l1_req_conflict | output | 1 | Overlapping bytes in the store batch |
| l1_rsp_valid | input | 1 | Read data returned |
| l1_rsp_rdata | input | LINE_BYTES*8 | Returned line |

## Verification
The assertions check the following on every cycle: the cache request holds steady while it waits for ready, completion pulses last one cycle and never coincide with an offered request, and a pulsed row was busy before and is free after. The scenarios are needed to show which rows the batch includes and what the merged mask, assembled store data, conflict flag and returned line are worth. The bench sweeps all occupancy patterns of a four-row buffer with varied line matches and both operation kinds. It also covers late arrivals and writes to busy rows, which only show up in the sequence of batches.

// File: rtl/l0mb_pkg.sv
// Shared types for the line-coalescing request buffer.
package l0mb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } l0mb_state_e;
endpackage

// File: rtl/l0mb_row.sv
// One request row, written only by its own function unit.
// Assumes: clr is only raised for rows that are busy; a write to a busy row is dropped.
module l0mb_row #(
    parameter int LINE_AW    = 44,
    parameter int LINE_BYTES = 16,
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_store,
    input  logic [LINE_AW-1:0]    wr_line,
    input  logic [LINE_BYTES-1:0] wr_mask,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  clr,
    output logic                  busy,
    output logic                  store,
    output logic [LINE_AW-1:0]    line,
    output logic [LINE_BYTES-1:0] mask,
    output logic [DATA_W-1:0]     data
);
    logic take;
    assign take = wr_en && !busy;

    // Occupancy flag: set on a write to a free row, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (clr)   busy <= 1'b0;
        else if (take)  busy <= 1'b1;
    end

    // Payload capture; only loaded when the row is free.
    always_ff @(posedge clk) begin
        if (take) begin
            store <= wr_store;
            line  <= wr_line;
            mask  <= wr_mask;
            data  <= wr_data;
        end
    end
endmodule

// File: rtl/l0mb_group.sv
// Picks the lowest busy row as leader and marks every busy row with the same line.
// Also reports whether any two marked rows enable a common byte.
module l0mb_group #(
    parameter int N_ROWS     = 8,
    parameter int LINE_AW    = 44,
    parameter int LINE_BYTES = 16
) (
    input  logic [N_ROWS-1:0]            busy,
    input  logic [N_ROWS-1:0]            store,
    input  logic [N_ROWS*LINE_AW-1:0]    line_f,
    input  logic [N_ROWS*LINE_BYTES-1:0] mask_f,
    output logic [N_ROWS-1:0]            group,
    output logic [LINE_AW-1:0]           lead_line,
    output logic                         lead_store,
    output logic                         overlap
);
    // Leader search: first busy row from index 0 upward.
    always_comb begin
        logic found;
        found      = 1'b0;
        lead_line  = '0;
        lead_store = 1'b0;
        for (int r = 0; r < N_ROWS; r++) begin
            if (busy[r] && !found) begin
                found      = 1'b1;
                lead_line  = line_f[r*LINE_AW +: LINE_AW];
                lead_store = store[r];
            end
        end
    end

    // Membership and byte overlap across members.
    always_comb begin
        logic [LINE_BYTES-1:0] seen;
        seen    = '0;
        overlap = 1'b0;
        for (int r = 0; r < N_ROWS; r++) begin
            group[r] = busy[r] && (line_f[r*LINE_AW +: LINE_AW] == lead_line);
            if (group[r]) begin
                overlap = overlap || ((seen & mask_f[r*LINE_BYTES +: LINE_BYTES]) != '0);
                seen    = seen | mask_f[r*LINE_BYTES +: LINE_BYTES];
            end
        end
    end
endmodule

// File: rtl/l0mb_merge.sv
// ORs the masks of the selected rows and assembles store data byte by byte.
// On a shared byte the lowest-indexed selected row wins.
module l0mb_merge #(
    parameter int N_ROWS     = 8,
    parameter int LINE_BYTES = 16,
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic [N_ROWS-1:0]            sel,
    input  logic [N_ROWS*LINE_BYTES-1:0] mask_f,
    input  logic [N_ROWS*DATA_W-1:0]     data_f,
    output logic [LINE_BYTES-1:0]        or_mask,
    output logic [DATA_W-1:0]            wdata
);
    // Walk rows from highest to lowest so lower rows overwrite shared bytes.
    always_comb begin
        or_mask = '0;
        wdata   = '0;
        for (int r = N_ROWS - 1; r >= 0; r--) begin
            if (sel[r]) begin
                or_mask = or_mask | mask_f[r*LINE_BYTES +: LINE_BYTES];
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (mask_f[r*LINE_BYTES + b])
                        wdata[b*8 +: 8] = data_f[r*DATA_W + b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/l0_merge_buf.sv
// Line-coalescing request buffer for one cache lane.
// Each function unit owns one row. Busy rows that share the leader's line are
// issued as a single read or write to the cache, then all complete together.
// Assumes: rows busy at the same time are all loads or all stores.
module l0_merge_buf
    import l0mb_pkg::*;
#(
    parameter int N_ROWS     = 8,
    parameter int LINE_AW    = 44,
    parameter int LINE_BYTES = 16,
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_ROWS-1:0]            wr_en,
    input  logic [N_ROWS-1:0]            wr_store,
    input  logic [N_ROWS*LINE_AW-1:0]    wr_line,
    input  logic [N_ROWS*LINE_BYTES-1:0] wr_mask,
    input  logic [N_ROWS*DATA_W-1:0]     wr_data,
    output logic [N_ROWS-1:0]            row_busy,
    output logic [N_ROWS-1:0]            done,
    output logic [DATA_W-1:0]            rd_line,
    output logic                         l1_req_valid,
    input  logic                         l1_req_ready,
    output logic                         l1_req_write,
    output logic [LINE_AW-1:0]           l1_req_line,
    output logic [LINE_BYTES-1:0]        l1_req_mask,
    output logic [DATA_W-1:0]            l1_req_wdata,
    output logic                         l1_req_conflict,
    input  logic                         l1_rsp_valid,
    input  logic [DATA_W-1:0]            l1_rsp_rdata
);
    logic [N_ROWS-1:0]            row_store;
    logic [N_ROWS*LINE_AW-1:0]    row_line;
    logic [N_ROWS*LINE_BYTES-1:0] row_mask;
    logic [N_ROWS*DATA_W-1:0]     row_data;
    logic [N_ROWS-1:0]            clr;

    logic [N_ROWS-1:0]  grp;
    logic [LINE_AW-1:0] grp_line;
    logic               grp_store;
    logic               grp_overlap;

    l0mb_state_e        state;
    logic [N_ROWS-1:0]  batch_q;
    logic [LINE_AW-1:0] line_q;
    logic               store_q;
    logic               conflict_q;
    logic               finish;

    // One private row per function unit.
    for (genvar g = 0; g < N_ROWS; g++) begin : g_row
        l0mb_row #(.LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_store (wr_store[g]),
            .wr_line  (wr_line[g*LINE_AW +: LINE_AW]),
            .wr_mask  (wr_mask[g*LINE_BYTES +: LINE_BYTES]),
            .wr_data  (wr_data[g*DATA_W +: DATA_W]),
            .clr      (clr[g]),
            .busy     (row_busy[g]),
            .store    (row_store[g]),
            .line     (row_line[g*LINE_AW +: LINE_AW]),
            .mask     (row_mask[g*LINE_BYTES +: LINE_BYTES]),
            .data     (row_data[g*DATA_W +: DATA_W])
        );
    end

    l0mb_group #(.N_ROWS(N_ROWS), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)) u_group (
        .busy       (row_busy),
        .store      (row_store),
        .line_f     (row_line),
        .mask_f     (row_mask),
        .group      (grp),
        .lead_line  (grp_line),
        .lead_store (grp_store),
        .overlap    (grp_overlap)
    );

    l0mb_merge #(.N_ROWS(N_ROWS), .LINE_BYTES(LINE_BYTES)) u_merge (
        .sel     (batch_q),
        .mask_f  (row_mask),
        .data_f  (row_data),
        .or_mask (l1_req_mask),
        .wdata   (l1_req_wdata)
    );

    // Completion condition: store handshake or load response.
    always_comb begin
        finish = ((state == ST_ISSUE) && l1_req_ready && store_q) ||
                 ((state == ST_WAIT) && l1_rsp_valid);
        clr    = finish ? batch_q : '0;
    end

    // Batch sequencer: form, issue, wait, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            batch_q    <= '0;
            line_q     <= '0;
            store_q    <= 1'b0;
            conflict_q <= 1'b0;
            done       <= '0;
        end else begin
            done <= finish ? batch_q : '0;
            case (state)
                ST_IDLE: if (|row_busy) begin
                    batch_q    <= grp;
                    line_q     <= grp_line;
                    store_q    <= grp_store;
                    conflict_q <= grp_overlap && grp_store;
                    state      <= ST_ISSUE;
                end
                ST_ISSUE: if (l1_req_ready) begin
                    state <= store_q ? ST_IDLE : ST_WAIT;
                end
                ST_WAIT: if (l1_rsp_valid) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Returned line register, updated with the load completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 rd_line <= '0;
        else if ((state == ST_WAIT) && l1_rsp_valid) rd_line <= l1_rsp_rdata;
    end

    assign l1_req_valid    = (state == ST_ISSUE);
    assign l1_req_write    = store_q;
    assign l1_req_line     = line_q;
    assign l1_req_conflict = (state == ST_ISSUE) && conflict_q;
endmodule

// File: rtl/l0mb_checker.sv
// Cycle-by-cycle properties of the line-coalescing buffer, bound to every instance.
module l0mb_checker #(
    parameter int N_ROWS     = 8,
    parameter int LINE_AW    = 44,
    parameter int LINE_BYTES = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_ROWS-1:0]     row_busy,
    input logic [N_ROWS-1:0]     done,
    input logic                  l1_req_valid,
    input logic                  l1_req_ready,
    input logic                  l1_req_write,
    input logic [LINE_AW-1:0]    l1_req_line,
    input logic [LINE_BYTES-1:0] l1_req_mask
);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req_valid && !l1_req_ready) |=> (l1_req_valid && $stable(l1_req_line) &&
                                            $stable(l1_req_mask) && $stable(l1_req_write)));

    p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> (done == '0));

    p_freed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |-> ((done & row_busy) == '0));

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        l1_req_valid |-> (done == '0));

    p_was_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |-> ((done & ~$past(row_busy)) == '0));
endmodule

bind l0_merge_buf l0mb_checker #(
    .N_ROWS(N_ROWS), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)
) u_l0mb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_busy     (row_busy),
    .done         (done),
    .l1_req_valid (l1_req_valid),
    .l1_req_ready (l1_req_ready),
    .l1_req_write (l1_req_write),
    .l1_req_line  (l1_req_line),
    .l1_req_mask  (l1_req_mask)
);

// File: tb/l0_merge_buf_bench.sv
`timescale 1ns/1ps
module l0_merge_buf_bench;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int NB = 16;
    localparam int DW = NB * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    wr_en = '0;
    logic [N-1:0]    wr_store = '0;
    logic [N*AW-1:0] wr_line = '0;
    logic [N*NB-1:0] wr_mask = '0;
    logic [N*DW-1:0] wr_data = '0;
    logic [N-1:0]    row_busy, done;
    logic [DW-1:0]   rd_line;
    logic            l1_req_valid, l1_req_write, l1_req_conflict;
    logic            l1_req_ready = 1'b0;
    logic [AW-1:0]   l1_req_line;
    logic [NB-1:0]   l1_req_mask;
    logic [DW-1:0]   l1_req_wdata;
    logic            l1_rsp_valid = 1'b0;
    logic [DW-1:0]   l1_rsp_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model of what each row currently holds.
    logic [AW-1:0] m_line [N];
    logic [NB-1:0] m_mask [N];
    logic [DW-1:0] m_data [N];
    logic          m_store;

    always #10 clk = ~clk;

    l0_merge_buf #(.N_ROWS(N), .LINE_AW(AW), .LINE_BYTES(NB)) u_l0_merge_buf (
        .clk, .rst_n, .wr_en, .wr_store, .wr_line, .wr_mask, .wr_data,
        .row_busy, .done, .rd_line,
        .l1_req_valid, .l1_req_ready, .l1_req_write, .l1_req_line,
        .l1_req_mask, .l1_req_wdata, .l1_req_conflict,
        .l1_rsp_valid, .l1_rsp_rdata
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] ln);
        logic [DW-1:0] v;
        for (int b = 0; b < NB; b++) v[b*8 +: 8] = 8'(ln * 17 + b + 3);
        return v;
    endfunction

    // Write the rows in sel in one cycle, from the model arrays.
    task automatic load(input logic [N-1:0] sel);
        @(negedge clk);
        for (int r = 0; r < N; r++) begin
            wr_line[r*AW +: AW] = m_line[r];
            wr_mask[r*NB +: NB] = m_mask[r];
            wr_data[r*DW +: DW] = m_data[r];
        end
        wr_store = {N{m_store}};
        wr_en    = sel;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wait_req();
        int t = 0;
        while (!l1_req_valid && t < 50) begin
            @(negedge clk);
            t++;
        end
    endtask

    // Serve batches until every row of pend has completed, checking each one.
    task automatic serve(input logic [N-1:0] pend_in);
        logic [N-1:0] pend = pend_in;
        int guard = 0;
        while (pend != 0 && guard < 8) begin
            int lead = -1;
            logic [N-1:0]  grp = '0;
            logic [NB-1:0] om = '0, seen = '0;
            logic [DW-1:0] wd = '0;
            logic          ovl = 1'b0;
            guard++;
            for (int r = 0; r < N; r++) if (pend[r] && lead < 0) lead = r;
            for (int r = 0; r < N; r++)
                if (pend[r] && m_line[r] == m_line[lead]) begin
                    grp[r] = 1'b1;
                    if ((seen & m_mask[r]) != 0) ovl = 1'b1;
                    seen = seen | m_mask[r];
                end
            for (int r = N - 1; r >= 0; r--)
                if (grp[r]) begin
                    om = om | m_mask[r];
                    for (int b = 0; b < NB; b++)
                        if (m_mask[r][b]) wd[b*8 +: 8] = m_data[r][b*8 +: 8];
                end
            wait_req();
            chk("R3 req valid", DW'(l1_req_valid), DW'(1));
            chk("R3 line", DW'(l1_req_line), DW'(m_line[lead]));
            chk("R3 write flag", DW'(l1_req_write), DW'(m_store));
            chk("R4 mask", DW'(l1_req_mask), DW'(om));
            chk("R7 conflict", DW'(l1_req_conflict), DW'(ovl && m_store));
            if (m_store) chk("R6 wdata", l1_req_wdata, wd);
            l1_req_ready = 1'b1;
            @(negedge clk);
            l1_req_ready = 1'b0;
            if (!m_store) begin
                chk("R10 no done before response", DW'(done), '0);
                l1_rsp_valid = 1'b1;
                l1_rsp_rdata = line_of(m_line[lead]);
                @(negedge clk);
                l1_rsp_valid = 1'b0;
                chk("R10 done", DW'(done), DW'(grp));
                chk("R10 rd_line", rd_line, line_of(m_line[lead]));
            end else begin
                chk("R9 done", DW'(done), DW'(grp));
            end
            chk("R9 rows freed", DW'(row_busy & grp), '0);
            pend = pend & ~grp;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", DW'(row_busy), '0);
        chk("R1 req", DW'(l1_req_valid), '0);
        chk("R1 done", DW'(done), '0);
        rst_n = 1'b1;

        // Sweep every occupancy pattern, both kinds, with varied line matches.
        for (int p = 1; p < (1 << N); p++) begin
            for (int k = 0; k < 2; k++) begin
                m_store = k[0];
                for (int r = 0; r < N; r++) begin
                    m_line[r] = AW'((p + r * (k + 1) + (r >> 1)) % 3);
                    m_mask[r] = (p % 3 == 0) ? NB'(16'h00FF << (2 * r))
                                             : NB'(16'h000F << (4 * r));
                    for (int b = 0; b < NB; b++)
                        m_data[r][b*8 +: 8] = 8'(r * 16 + b + p);
                end
                load(N'(p));
                chk("R2 busy after write", DW'(row_busy), DW'(p));
                serve(N'(p));
            end
        end

        // Late arrival and write to a busy row.
        m_store = 1'b0;
        m_line[0] = 4'd3; m_mask[0] = 16'h0003; m_data[0] = '0;
        load(4'b0001);
        wait_req();
        @(negedge clk);
        wr_line[0 +: AW] = 4'd5;
        wr_mask[0 +: NB] = 16'hFFFF;
        wr_line[AW +: AW] = 4'd3;
        wr_mask[NB +: NB] = 16'h0300;
        wr_store = '0;
        wr_en = 4'b0011;
        @(negedge clk);
        wr_en = '0;
        chk("R8 held line", DW'(l1_req_line), DW'(3));
        chk("R5 batch mask excludes late row", DW'(l1_req_mask), DW'(16'h0003));
        chk("R2 busy row ignored, late row taken", DW'(row_busy), DW'(4'b0011));
        l1_req_ready = 1'b1;
        @(negedge clk);
        l1_req_ready = 1'b0;
        l1_rsp_valid = 1'b1;
        l1_rsp_rdata = line_of(4'd3);
        @(negedge clk);
        l1_rsp_valid = 1'b0;
        chk("R5 first batch done", DW'(done), DW'(4'b0001));
        m_line[1] = 4'd3; m_mask[1] = 16'h0300; m_data[1] = '0;
        serve(4'b0010);
        @(negedge clk);
        chk("R2 ignored write left no request", DW'(row_busy), '0);
        chk("R2 no further request", DW'(l1_req_valid), '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule